// File: doc/BRIEF.md
# Prefix Remap and Storage-Key Recorder

This block follows the address translator of a processor core. It takes a real address and turns it into an absolute address by exchanging two 8 KB windows. The window at address zero is moved to the per-CPU prefix area, and the prefix area is moved to address zero. All other addresses pass through unchanged. The same remap applies when translation is off, because the real address is then the logical address fed in unchanged.

For an access that the translator reported as successful, and whose absolute address lies inside the installed memory, the block then updates the storage key of the 4 KB page that was touched. It reads the key from an external synchronous key RAM and writes it back with the reference bit set when read permission was granted and the change bit set when write permission was granted. While that read-then-write runs, the block drops its ready output and ignores new requests.

Top module: `prefix_skey_unit`

## Requirements
- R1: A real address below 0x2000 becomes the real address plus the prefix.
- R2: A real address at or above the prefix and below prefix + 0x2000 becomes the real address minus the prefix. The low-window rule of R1 takes priority when the prefix is zero.
- R3: Every other real address, including prefix + 0x2000 and 0x2000 itself, is passed through unchanged.
- R4: Bits 12..0 of `prefix_base` have no effect on the absolute address.
- R5: A key update is started only for an accepted request with `req_ok` high and an absolute address below `mem_limit`. Otherwise `key_re` and `key_we` stay low and `req_ready` stays high.
- R6: `key_idx` equals the absolute address shifted right by 12, and it is held steady across the read and the write of one update.
- R7: `key_wdata` is the key read back with bit 2 (reference) set when `req_perm_rd` was high and bit 1 (change) set when `req_perm_wr` was high. All other key bits are kept.
- R8: `abs_valid` is high for one cycle in the cycle after a request is accepted, with `abs_addr` valid and held until the next accept. For an updating request, `key_re` is high in that same cycle and `key_we` is high in the cycle after it.
- R9: `req_ready` is low from the cycle after an updating accept until the write cycle has ended. A request presented while `req_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_raddr | input | ADDR_W | Real address from the translator |
| req_ok | input | 1 | Translation succeeded |
| req_perm_rd | input | 1 | Read permission granted |
| req_perm_wr | input | 1 | Write permission granted |
| prefix_base | input | ADDR_W | Prefix register, 8 KB aligned |
| mem_limit | input | ADDR_W | Installed memory size in bytes |
| abs_valid | output | 1 | One-cycle pulse: abs_addr updated |
| abs_addr | output | ADDR_W | Absolute address |
| key_idx | output | ADDR_W-12 | Page index into the key RAM |
| key_re | output | 1 | Key RAM read strobe |
| key_rdata | input | KEY_W | Key RAM read data, one cycle after key_re |
| key_we | output | 1 | Key RAM write strobe |
| key_wdata | output | KEY_W | Key RAM write data |

## Verification
The absolute address and its `abs_valid` pulse are registered once, so they are due one cycle after the accepting edge. The key read strobe is due in that same cycle, and the write strobe, index and data one cycle later. The updated key is in the RAM after a third edge, and `req_ready` returns at that point. The bench drives inputs and samples outputs on falling edges, and it steps one falling edge per stage, so that each check lands in the cycle its result is due.

// File: rtl/psk_pkg.sv
package psk_pkg;
  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_READ  = 2'd1,
    KS_WRITE = 2'd2
  } key_state_e;
endpackage

// File: rtl/psk_remap.sv
module psk_remap #(
  parameter int ADDR_W    = 32,
  parameter int WIN_SHIFT = 13
) (
  input  logic [ADDR_W-1:0] raddr,
  input  logic [ADDR_W-1:0] prefix,
  output logic [ADDR_W-1:0] abs_addr,
  output logic              hit_low,
  output logic              hit_pfx
);
  localparam logic [ADDR_W:0]   WIN_BYTES = (ADDR_W+1)'(1) << WIN_SHIFT;
  localparam logic [ADDR_W-1:0] WIN_MASK  = ~((ADDR_W)'(1 << WIN_SHIFT) - (ADDR_W)'(1));

  function automatic logic [ADDR_W-1:0] align_pfx(input logic [ADDR_W-1:0] p);
    return p & WIN_MASK;
  endfunction

  function automatic logic in_low(input logic [ADDR_W-1:0] a);
    return {1'b0, a} < WIN_BYTES;
  endfunction

  function automatic logic in_pfx(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] p);
    logic [ADDR_W:0] top;
    top = {1'b0, p} + WIN_BYTES;
    return (a >= p) && ({1'b0, a} < top);
  endfunction

  logic [ADDR_W-1:0] pfx_al;

  always_comb begin
    pfx_al  = align_pfx(prefix);
    hit_low = in_low(raddr);
    hit_pfx = !hit_low && in_pfx(raddr, pfx_al);
    if (hit_low)      abs_addr = raddr + pfx_al;
    else if (hit_pfx) abs_addr = raddr - pfx_al;
    else              abs_addr = raddr;
  end
endmodule

// File: rtl/psk_qualify.sv
module psk_qualify #(
  parameter int ADDR_W = 32
) (
  input  logic              ok,
  input  logic [ADDR_W-1:0] abs_addr,
  input  logic [ADDR_W-1:0] limit,
  output logic              in_mem,
  output logic              upd_go
);
  function automatic logic below_limit(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] l);
    return a < l;
  endfunction

  always_comb begin
    in_mem = below_limit(abs_addr, limit);
    upd_go = ok && in_mem;
  end
endmodule

// File: rtl/psk_key_fsm.sv
module psk_key_fsm
  import psk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int KEY_W      = 7,
  parameter int REF_POS    = 2,
  parameter int CHG_POS    = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        abs_addr,
  input  logic                     perm_rd,
  input  logic                     perm_wr,
  input  logic [KEY_W-1:0]         key_rdata,
  output logic                     busy,
  output logic [ADDR_W-PAGE_SHIFT-1:0] key_idx,
  output logic                     key_re,
  output logic                     key_we,
  output logic [KEY_W-1:0]         key_wdata
);
  localparam int IDX_W = ADDR_W - PAGE_SHIFT;

  function automatic logic [KEY_W-1:0] mark_bits(input logic rd, input logic wr);
    logic [KEY_W-1:0] m;
    m = '0;
    m[REF_POS] = rd;
    m[CHG_POS] = wr;
    return m;
  endfunction

  function automatic logic [IDX_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_SHIFT];
  endfunction

  key_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [KEY_W-1:0] set_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
      idx_q   <= '0;
      set_q   <= '0;
    end else begin
      unique case (state_q)
        KS_IDLE: if (start) begin
          state_q <= KS_READ;
          idx_q   <= page_of(abs_addr);
          set_q   <= mark_bits(perm_rd, perm_wr);
        end
        KS_READ:  state_q <= KS_WRITE;
        KS_WRITE: state_q <= KS_IDLE;
        default:  state_q <= KS_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state_q != KS_IDLE);
    key_re    = (state_q == KS_READ);
    key_we    = (state_q == KS_WRITE);
    key_idx   = idx_q;
    key_wdata = key_rdata | set_q;
  end
endmodule

// File: rtl/prefix_skey_unit.sv
module prefix_skey_unit #(
  parameter int ADDR_W     = 32,
  parameter int WIN_SHIFT  = 13,
  parameter int PAGE_SHIFT = 12,
  parameter int KEY_W      = 7,
  parameter int REF_POS    = 2,
  parameter int CHG_POS    = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_raddr,
  input  logic                         req_ok,
  input  logic                         req_perm_rd,
  input  logic                         req_perm_wr,
  input  logic [ADDR_W-1:0]            prefix_base,
  input  logic [ADDR_W-1:0]            mem_limit,
  output logic                         abs_valid,
  output logic [ADDR_W-1:0]            abs_addr,
  output logic [ADDR_W-PAGE_SHIFT-1:0] key_idx,
  output logic                         key_re,
  input  logic [KEY_W-1:0]             key_rdata,
  output logic                         key_we,
  output logic [KEY_W-1:0]             key_wdata
);
  logic [ADDR_W-1:0] abs_next;
  logic              hit_low, hit_pfx, in_mem, upd_go;
  logic              busy, accept, upd_start;

  psk_remap #(.ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT)) u_remap (
    .raddr    (req_raddr),
    .prefix   (prefix_base),
    .abs_addr (abs_next),
    .hit_low  (hit_low),
    .hit_pfx  (hit_pfx)
  );

  psk_qualify #(.ADDR_W(ADDR_W)) u_qual (
    .ok       (req_ok),
    .abs_addr (abs_next),
    .limit    (mem_limit),
    .in_mem   (in_mem),
    .upd_go   (upd_go)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign upd_start = accept && upd_go;

  psk_key_fsm #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .KEY_W(KEY_W),
    .REF_POS(REF_POS), .CHG_POS(CHG_POS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (upd_start),
    .abs_addr  (abs_next),
    .perm_rd   (req_perm_rd),
    .perm_wr   (req_perm_wr),
    .key_rdata (key_rdata),
    .busy      (busy),
    .key_idx   (key_idx),
    .key_re    (key_re),
    .key_we    (key_we),
    .key_wdata (key_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abs_valid <= 1'b0;
      abs_addr  <= '0;
    end else begin
      abs_valid <= accept;
      if (accept) abs_addr <= abs_next;
    end
  end
endmodule

// File: rtl/psk_checker.sv
module psk_checker #(
  parameter int ADDR_W     = 32,
  parameter int WIN_SHIFT  = 13,
  parameter int PAGE_SHIFT = 12,
  parameter int KEY_W      = 7
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         accept,
  input logic                         upd_start,
  input logic                         req_ready,
  input logic [ADDR_W-1:0]            req_raddr,
  input logic [ADDR_W-1:0]            prefix_base,
  input logic                         abs_valid,
  input logic [ADDR_W-1:0]            abs_addr,
  input logic [ADDR_W-PAGE_SHIFT-1:0] key_idx,
  input logic                         key_re,
  input logic                         key_we,
  input logic [KEY_W-1:0]             key_rdata,
  input logic [KEY_W-1:0]             key_wdata
);
  localparam logic [ADDR_W-1:0] LOW_TOP = (ADDR_W)'(1 << WIN_SHIFT);
  localparam logic [ADDR_W-1:0] AL_MASK = ~(LOW_TOP - (ADDR_W)'(1));

  assert_low_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_raddr < LOW_TOP) |=>
      abs_addr == $past(req_raddr) + ($past(prefix_base) & AL_MASK));

  assert_skip_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !upd_start) |=> !key_re);

  assert_idx_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_we |-> $stable(key_idx));

  assert_keep_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_we |-> ((key_wdata & key_rdata) == key_rdata));

  assert_abs_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> abs_valid);

  assert_write_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_re |=> key_we);

  assert_read_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_re |-> $past(upd_start));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_re || key_we) |-> !req_ready);

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({key_re, key_we}));
endmodule

bind prefix_skey_unit psk_checker #(
  .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .PAGE_SHIFT(PAGE_SHIFT), .KEY_W(KEY_W)
) u_psk_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .upd_start   (upd_start),
  .req_ready   (req_ready),
  .req_raddr   (req_raddr),
  .prefix_base (prefix_base),
  .abs_valid   (abs_valid),
  .abs_addr    (abs_addr),
  .key_idx     (key_idx),
  .key_re      (key_re),
  .key_we      (key_we),
  .key_rdata   (key_rdata),
  .key_wdata   (key_wdata)
);

// File: tb/prefix_skey_unit_bench.sv
`timescale 1ns/1ps
module prefix_skey_unit_bench;
  localparam int AW = 32;
  localparam int KW = 7;
  localparam int IW = AW - 12;
  localparam logic [AW-1:0] MEMSZ = 32'h0010_0000;
  localparam logic [KW-1:0] KINIT = 7'h50;

  typedef struct packed {
    logic [31:0] raddr;
    logic [31:0] pfx;
    logic        ok;
    logic        rd;
    logic        wr;
    logic        upd;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [0:NV-1] = '{
    '{32'h0000_0123, 32'h0004_0000, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0004_0123}, // R1
    '{32'h0004_1FF8, 32'h0004_0000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_1FF8}, // R2
    '{32'h0004_2000, 32'h0004_0000, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0004_2000}, // R3 end excluded
    '{32'h0000_2000, 32'h0004_0000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_2000}, // R3 low edge
    '{32'h0000_1FFF, 32'h0004_1ABC, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0004_1FFF}, // R4
    '{32'h0003_FFFF, 32'h0004_0000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0003_FFFF}, // R3 below window
    '{32'h0000_0100, 32'h0004_0000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0004_0100}, // R5 failed
    '{32'h0010_0000, 32'h0004_0000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0010_0000}, // R5 beyond memory
    '{32'h000F_F000, 32'h0004_0000, 1'b1, 1'b0, 1'b0, 1'b1, 32'h000F_F000}, // R7 no marks
    '{32'h0000_0A00, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0A00}  // R2 zero prefix
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ok = 1'b0, req_perm_rd = 1'b0, req_perm_wr = 1'b0;
  logic [AW-1:0] req_raddr = '0, prefix_base = '0;
  logic [AW-1:0] mem_limit = MEMSZ;
  logic req_ready, abs_valid, key_re, key_we;
  logic [AW-1:0] abs_addr;
  logic [IW-1:0] key_idx;
  logic [KW-1:0] key_rdata, key_wdata;

  always #4 clk = ~clk;

  prefix_skey_unit u_prefix_skey_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_raddr(req_raddr), .req_ok(req_ok), .req_perm_rd(req_perm_rd),
    .req_perm_wr(req_perm_wr), .prefix_base(prefix_base), .mem_limit(mem_limit),
    .abs_valid(abs_valid), .abs_addr(abs_addr), .key_idx(key_idx), .key_re(key_re),
    .key_rdata(key_rdata), .key_we(key_we), .key_wdata(key_wdata)
  );

  logic [KW-1:0] kram [0:255];
  logic [KW-1:0] shadow [0:255];
  logic [KW-1:0] rd_q = '0;
  assign key_rdata = rd_q;
  always @(posedge clk) begin
    if (key_re) rd_q <= kram[key_idx[7:0]];
    if (key_we) kram[key_idx[7:0]] <= key_wdata;
  end

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  task automatic chk(input bit good, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cycles);
      finish_up();
    end
  end

  task automatic drive(input logic [31:0] ra, input logic [31:0] pf,
                       input logic ok, input logic rd, input logic wr);
    req_valid = 1'b1; req_raddr = ra; prefix_base = pf;
    req_ok = ok; req_perm_rd = rd; req_perm_wr = wr;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      kram[i] = KINIT;
      shadow[i] = KINIT;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(req_ready === 1'b1, "R9 ready after reset", {31'b0, req_ready}, 32'h1);
    chk({abs_valid, key_re, key_we} === 3'b000, "R8 idle strobes after reset",
        {29'b0, abs_valid, key_re, key_we}, 32'h0);
    chk(abs_addr === 32'h0, "R8 abs_addr after reset", abs_addr, 32'h0);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0]    pg;
      logic [KW-1:0] want;
      drive(VECS[v].raddr, VECS[v].pfx, VECS[v].ok, VECS[v].rd, VECS[v].wr);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(abs_valid === 1'b1 && abs_addr === VECS[v].exp, "R1/R2/R3/R4 abs_addr",
          abs_addr, VECS[v].exp);
      chk(key_re === VECS[v].upd, "R5/R8 key read strobe", {31'b0, key_re},
          {31'b0, VECS[v].upd});
      if (VECS[v].upd) begin
        pg = VECS[v].exp[19:12];
        want = shadow[pg];
        want[2] = want[2] | VECS[v].rd;
        want[1] = want[1] | VECS[v].wr;
        shadow[pg] = want;
        chk(req_ready === 1'b0, "R9 ready low during update", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
        chk(key_we === 1'b1 && key_idx === VECS[v].exp[31:12], "R6/R8 write cycle index",
            {12'b0, key_idx}, {12'b0, VECS[v].exp[31:12]});
        chk(key_wdata === want, "R7 write data", {25'b0, key_wdata}, {25'b0, want});
        @(negedge clk);
        chk(kram[pg] === want, "R7 stored key", {25'b0, kram[pg]}, {25'b0, want});
        chk(req_ready === 1'b1 && key_we === 1'b0, "R9 ready after write",
            {31'b0, req_ready}, 32'h1);
      end else begin
        chk(req_ready === 1'b1, "R5 no stall when skipped", {31'b0, req_ready}, 32'h1);
        @(negedge clk);
        chk(key_we === 1'b0, "R5 no key write", {31'b0, key_we}, 32'h0);
      end
    end

    // R9: request during busy is ignored
    drive(32'h0004_0010, 32'h0004_0000, 1'b1, 1'b0, 1'b1);
    @(posedge clk);
    @(negedge clk);
    drive(32'h0000_3000, 32'h0004_0000, 1'b1, 1'b1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(abs_valid === 1'b0 && abs_addr === 32'h0000_0010, "R9 busy request ignored",
        abs_addr, 32'h0000_0010);
    @(negedge clk);
    @(negedge clk);
    chk(kram[3] === KINIT, "R9 ignored request left key alone", {25'b0, kram[3]},
        {25'b0, KINIT});
    shadow[0][1] = 1'b1;
    chk(kram[0] === shadow[0], "R7 change bit on page 0", {25'b0, kram[0]},
        {25'b0, shadow[0]});

    // R8: back-to-back non-updating requests
    drive(32'h0000_0040, 32'h0002_0000, 1'b0, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk(abs_valid === 1'b1 && abs_addr === 32'h0002_0040, "R8 first of pair",
        abs_addr, 32'h0002_0040);
    drive(32'h0002_0040, 32'h0002_0000, 1'b0, 1'b1, 1'b0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(abs_valid === 1'b1 && abs_addr === 32'h0000_0040, "R8 second of pair",
        abs_addr, 32'h0000_0040);
    @(negedge clk);
    chk(abs_valid === 1'b0 && abs_addr === 32'h0000_0040, "R8 pulse ends, value held",
        abs_addr, 32'h0000_0040);

    done = 1'b1;
    finish_up();
  end
endmodule